// File: doc/BRIEF.md
# Line Buffer Reduction Sequencer

This block drives the pointer controls of one or two line-delay buffers so that they can scale, decimate, mosaic or wipe a video stream. It does not touch the pixel data. Every effect comes from gating the buffer's write and read pointer enables, pulsing its pointer resets and steering its output enables. All strobes are active low, as the buffer expects.

The host supplies a line-start pulse in the first cycle of every line and a field-start pulse in the first cycle of every field. The field-start pulse always coincides with a line-start pulse. It also supplies a mode code and a reduction factor. Each line carries up to 910 samples. The block keeps no pixel count of its own, so any line length works. The mode code and the factor are captured in the field-start cycle and take effect in that same cycle. Buffer A is the main buffer. Buffer B's read reset and output enable are used for the two-source wipe.

Top module: `line_reduce_seq`

## Requirements
- R1: While `rst_n` is low, all seven strobe outputs are high (inactive).
- R2: `a_rw_n`, `a_rr_n` and `b_rr_n` are low in exactly the cycles where `line_start` is high, so every line's pointers restart from 0.
- R3: Mode code 0, and the unused codes 6 and 7, pass data through. `a_we_n` and `a_re_n` are low in every cycle.
- R4: Mode code 1 (half horizontal) holds `a_we_n` and `a_re_n` low together only on even sample indices (index 0 is the line-start cycle).
- R5: Mode code 2 (half line) holds `a_we_n` low for every sample of even-numbered lines of the field (line 0 is the field-start line) and high on odd lines. `a_re_n` is low on even sample indices.
- R6: Mode code 3 (n-by-n reduce) holds `a_we_n` low when the sample index mod n is 0 and the line index mod n is 0. `a_re_n` is low when the sample index mod n is 0. With n = 1 it behaves as pass-through.
- R7: Mode code 4 (n-by-n mosaic) gates `a_we_n` as in R6. `a_re_n` is low only when the sample index mod n equals n-1, so each kept sample is presented n times.
- R8: Mode code 5 (field wipe) keeps both enables low every cycle. Fields are counted from 0 since reset. Buffer A drives (`a_oe_n` low, `b_oe_n` high) on even fields and buffer B drives on odd fields.
- R9: Outside wipe mode `a_oe_n` is low and `b_oe_n` is high. `a_oe_n` and `b_oe_n` are never both low.
- R10: `mode` and `factor` are sampled only in the field-start cycle. Changes to them in any other cycle have no effect on the outputs.
- R11: A `factor` of 0 is treated as 1, and values above 8 are treated as 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_start | input | 1 | High in the first cycle of each line |
| field_start | input | 1 | High in the first cycle of each field, together with line_start |
| mode | input | 3 | Effect selector, captured at field start |
| factor | input | 4 | Reduction factor n, captured at field start |
| a_we_n | output | 1 | Buffer A write enable, active low |
| a_re_n | output | 1 | Buffer A read enable, active low |
| a_rw_n | output | 1 | Buffer A write pointer reset, active low |
| a_rr_n | output | 1 | Buffer A read pointer reset, active low |
| a_oe_n | output | 1 | Buffer A output enable, active low |
| b_rr_n | output | 1 | Buffer B read pointer reset, active low |
| b_oe_n | output | 1 | Buffer B output enable, active low |

## Verification
The assertions assume that `field_start` never arrives without `line_start`. They also assume that no field starts in the cycle that follows reset release. The stimulus obeys both assumptions: every field opens with both pulses together, and at least one idle cycle follows reset. Mode and factor are scrambled on every non-field-start cycle, which exercises the capture rule. The sweep covers every mode code and every factor value over fields of nine 20-sample lines, and adds a full 910-sample run.

// File: rtl/line_reduce_seq.sv
module line_reduce_seq #(
  parameter int NW   = 4,
  parameter int NMAX = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          line_start,
  input  logic          field_start,
  input  logic [2:0]    mode,
  input  logic [NW-1:0] factor,
  output logic          a_we_n,
  output logic          a_re_n,
  output logic          a_rw_n,
  output logic          a_rr_n,
  output logic          a_oe_n,
  output logic          b_rr_n,
  output logic          b_oe_n
);
  localparam logic [2:0] M_HALFH = 3'd1;
  localparam logic [2:0] M_HALFL = 3'd2;
  localparam logic [2:0] M_RED   = 3'd3;
  localparam logic [2:0] M_MOS   = 3'd4;
  localparam logic [2:0] M_WIPE  = 3'd5;
  localparam logic [NW-1:0] ONE  = NW'(1);

  logic [2:0]    mode_q, mode_eff;
  logic [NW-1:0] n_q, n_eff, n_in;
  logic [NW-1:0] hn, vn, hph_q, hph_eff, hph_nx, vph_q, vph_eff, vph_inc;
  logic          fsel_q, fsel_eff, we_act, re_act, wipe;

  assign n_in     = (factor == '0) ? ONE : ((factor > NW'(NMAX)) ? NW'(NMAX) : factor);
  assign mode_eff = field_start ? mode : mode_q;
  assign n_eff    = field_start ? n_in : n_q;
  assign fsel_eff = field_start ? ~fsel_q : fsel_q;
  assign wipe     = (mode_eff == M_WIPE);

  always_comb begin
    hn = ONE;
    vn = ONE;
    case (mode_eff)
      M_HALFH: hn = NW'(2);
      M_HALFL: begin hn = NW'(2); vn = NW'(2); end
      M_RED, M_MOS: begin hn = n_eff; vn = n_eff; end
      default: ;
    endcase
  end

  assign hph_eff = line_start ? '0 : hph_q;
  assign hph_nx  = (hph_eff + ONE >= hn) ? '0 : hph_eff + ONE;
  assign vph_inc = (vph_q + ONE >= vn) ? '0 : vph_q + ONE;
  assign vph_eff = field_start ? '0 : (line_start ? vph_inc : vph_q);

  always_comb begin
    we_act = 1'b1;
    re_act = 1'b1;
    case (mode_eff)
      M_HALFH: begin
        we_act = (hph_eff == '0);
        re_act = (hph_eff == '0);
      end
      M_HALFL: begin
        we_act = (vph_eff == '0);
        re_act = (hph_eff == '0);
      end
      M_RED: begin
        we_act = (hph_eff == '0) && (vph_eff == '0);
        re_act = (hph_eff == '0);
      end
      M_MOS: begin
        we_act = (hph_eff == '0) && (vph_eff == '0);
        re_act = (hph_eff == hn - ONE);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= '0;
      n_q    <= ONE;
      hph_q  <= '0;
      vph_q  <= '0;
      fsel_q <= 1'b1;
    end else begin
      mode_q <= mode_eff;
      n_q    <= n_eff;
      hph_q  <= hph_nx;
      vph_q  <= vph_eff;
      fsel_q <= fsel_eff;
    end
  end

  assign a_we_n = !(rst_n && we_act);
  assign a_re_n = !(rst_n && re_act);
  assign a_rw_n = !(rst_n && line_start);
  assign a_rr_n = !(rst_n && line_start);
  assign b_rr_n = !(rst_n && line_start);
  assign a_oe_n = !(rst_n && !(wipe && fsel_eff));
  assign b_oe_n = !(rst_n && wipe && fsel_eff);
endmodule

module line_reduce_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       line_start,
  input logic       field_start,
  input logic [2:0] mode_eff,
  input logic       a_we_n,
  input logic       a_re_n,
  input logic       a_rw_n,
  input logic       a_rr_n,
  input logic       a_oe_n,
  input logic       b_rr_n,
  input logic       b_oe_n
);
  always_comb begin
    if (!rst_n)
      AST_IDLE_IN_RESET: assert ({a_we_n, a_re_n, a_rw_n, a_rr_n, a_oe_n, b_rr_n, b_oe_n} == 7'h7f); // R1
  end

  AST_LINE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    line_start |-> (!a_rw_n && !a_rr_n && !b_rr_n)); // R2
  AST_NO_STRAY_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !line_start |-> (a_rw_n && a_rr_n && b_rr_n)); // R2
  AST_HALFH_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (!a_we_n && mode_eff == 3'd1 && !line_start) |=> (a_we_n || line_start)); // R4
  AST_SINGLE_DRIVER: assert property (@(posedge clk) disable iff (!rst_n)
    !(!a_oe_n && !b_oe_n)); // R9
  AST_WIPE_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (field_start && mode_eff == 3'd5 && $past(mode_eff) == 3'd5) |-> (a_oe_n != $past(a_oe_n))); // R8
endmodule

bind line_reduce_seq line_reduce_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .line_start(line_start), .field_start(field_start),
  .mode_eff(mode_eff), .a_we_n(a_we_n), .a_re_n(a_re_n), .a_rw_n(a_rw_n),
  .a_rr_n(a_rr_n), .a_oe_n(a_oe_n), .b_rr_n(b_rr_n), .b_oe_n(b_oe_n)
);

// File: tb/line_reduce_seq_test.sv
module line_reduce_seq_test;
  logic clk = 0, rst_n = 0, line_start = 0, field_start = 0;
  logic [2:0] mode = 0;
  logic [3:0] factor = 0;
  logic a_we_n, a_re_n, a_rw_n, a_rr_n, a_oe_n, b_rr_n, b_oe_n;
  int errors = 0, checks = 0, fields = 0;
  bit done = 0;

  always #5 clk = ~clk;

  line_reduce_seq uut (.*);

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s t=%0t actual=%b expected=%b", req, $time, act, exp);
    end
  endtask

  function automatic string tag(input int m, input int f);
    if ((m == 3 || m == 4) && (f == 0 || f > 8)) return "R11";
    case (m)
      1: return "R4";
      2: return "R5";
      3: return "R6";
      4: return "R7";
      5: return "R8";
      default: return "R3";
    endcase
  endfunction

  task automatic run_field(input int m, input int f, input int lines, input int px);
    int n = (f == 0) ? 1 : ((f > 8) ? 8 : f);
    int mm = (m > 5) ? 0 : m;
    bit bdrv = (mm == 5) && (fields % 2 == 1);
    string t = tag(m, f);
    for (int l = 0; l < lines; l++) begin
      for (int p = 0; p < px; p++) begin
        logic ew, er;
        @(negedge clk);
        line_start  = (p == 0);
        field_start = (p == 0 && l == 0);
        mode   = field_start ? 3'(m) : ~3'(m);
        factor = field_start ? 4'(f) : ~4'(f);
        #2;
        ew = 1; er = 1;
        case (mm)
          1: begin ew = (p % 2 == 0); er = ew; end
          2: begin ew = (l % 2 == 0); er = (p % 2 == 0); end
          3: begin ew = (p % n == 0) && (l % n == 0); er = (p % n == 0); end
          4: begin ew = (p % n == 0) && (l % n == 0); er = (p % n == n - 1); end
          default: ;
        endcase
        chk(t, a_we_n, !ew);
        chk(t, a_re_n, !er);
        if (l == lines - 1 && p == px - 1) chk("R10", a_we_n, !ew);
        chk("R2", a_rw_n, !(p == 0));
        chk("R2", a_rr_n, !(p == 0));
        chk("R2", b_rr_n, !(p == 0));
        chk(mm == 5 ? "R8" : "R9", a_oe_n, bdrv);
        chk(mm == 5 ? "R8" : "R9", b_oe_n, !bdrv);
      end
    end
    fields++;
  endtask

  initial begin
    @(negedge clk);
    line_start = 1; field_start = 1; mode = 3'd5;
    repeat (3) begin
      @(negedge clk); #2;
      chk("R1", a_we_n, 1); chk("R1", a_re_n, 1); chk("R1", a_rw_n, 1);
      chk("R1", a_rr_n, 1); chk("R1", a_oe_n, 1); chk("R1", b_rr_n, 1);
      chk("R1", b_oe_n, 1);
    end
    line_start = 0; field_start = 0; mode = 0;
    @(negedge clk) rst_n = 1;
    @(negedge clk);
    for (int m = 0; m < 8; m++)
      for (int f = 0; f < 16; f++)
        run_field(m, f, 9, 20);
    run_field(5, 2, 2, 20);
    run_field(5, 2, 2, 20);
    run_field(1, 0, 2, 910);
    run_field(4, 3, 3, 910);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1500000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule